// File: doc/BRIEF.md
# JPEG Scan Byte Unstuffer

This block sits in the entropy-coded byte path of a JPEG decoder, between the input byte buffer and the Huffman decoder. Every scan byte that the encoder stuffed arrives as an escape byte 0xFF followed by 0x00. The block turns that pair back into one 0xFF data byte. It swallows 0xFF fill bytes and drops any marker it does not need.

The block reports two markers to the decoder as event beats that carry no data: a restart marker (0xD0 to 0xD7) and the end-of-image marker (0xD9). Every output beat carries a 4-bit context word. Its low two bits copy the header-status inputs. Its upper two bits flag the end of an entropy segment and the end of the image. When the end-of-image marker is seen, a one-cycle pulse goes back to the input side so that it can flush and stop feeding bytes.

Both sides use valid/ready handshakes. Input is taken only in cycles where the downstream side is ready, so a stall holds the whole block still.

Top module: `jpeg_scan_unstuffer`

## Requirements
- R1: With no escape pending, an accepted byte other than 0xFF appears on `out_data` with `out_valid` high in the cycle after it is accepted. Its `out_ctx[3:2]` is 00.
- R2: An accepted 0xFF followed by an accepted 0x00 produces exactly one data beat, 0xFF, with `out_ctx[3:2]` = 00. The 0x00 is not forwarded.
- R3: A 0xFF produces no beat in the cycle after it is accepted. After a 0xFF, a nonzero code that is not 0xFF, not 0xD0..0xD7 and not 0xD9 produces no beat at all, and the escape is then cleared.
- R4: Extra 0xFF bytes after a pending 0xFF are fill. They produce no beat and keep the escape pending. For example, FF FF FF 00 yields a single 0xFF data beat.
- R5: A 0xFF followed by 0xD0..0xD7 produces one event beat: `out_data` = 0x00, `out_ctx[2]` = 1, `out_ctx[3]` = 0.
- R6: A 0xFF followed by 0xD9 produces one event beat: `out_data` = 0x00, `out_ctx[3:2]` = 11. `img_end` is high for exactly the one cycle after the 0xD9 is accepted.
- R7: `out_ctx[0]` carries `hdr_valid` and `out_ctx[1]` carries `hdr_bank`, both sampled in the cycle the byte that completes the beat is accepted.
- R8: `in_ready` equals `out_ready`. While `out_ready` is low, no byte is consumed, and `out_valid`, `out_data` and `out_ctx` hold their values.
- R9: A beat stays valid until a cycle with `out_ready` high. After that cycle `out_valid` is low unless a new beat was loaded.
- R10: A synchronous active-low reset clears `out_valid`, `out_data`, `out_ctx`, `img_end` and the pending-escape state. A 0x00 accepted first after reset is forwarded as data 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input scan byte |
| in_ready | output | 1 | Block takes `in_data` at this edge if `in_valid` |
| hdr_valid | input | 1 | Header-status flag copied into context bit 0 |
| hdr_bank | input | 1 | Header bank select copied into context bit 1 |
| out_valid | output | 1 | Output beat present |
| out_data | output | 8 | Unstuffed data byte (0x00 on event beats) |
| out_ctx | output | 4 | Context: bit0 header valid, bit1 bank, bit2 segment end, bit3 image end |
| out_ready | input | 1 | Downstream takes the beat at this edge |
| img_end | output | 1 | One-cycle end-of-image pulse to the input side |

## Verification
Every result is due one clock edge after the byte that causes it is accepted: a data or event beat, the context bits, the `img_end` pulse and the dropping of `out_valid` after a transfer. A stall keeps the previous values for as long as `out_ready` stays low. The bench drives inputs on the falling edge and steps a reference model once per cycle. It compares all outputs at the next falling edge, exactly one register stage later. Random bytes are weighted toward 0xFF, 0x00 and marker codes, and readiness gaps are random, so that escape chains, markers and stalls collide often.

// File: rtl/jpeg_unstuff_pkg.sv
// Shared constants and types for the scan byte unstuffer.
// Assumes an 8-bit byte path and a 4-bit context word.
package jpeg_unstuff_pkg;

    localparam int BYTE_W      = 8;
    localparam int CTX_W       = 4;
    localparam int CTX_HDR_OK  = 0;
    localparam int CTX_BANK    = 1;
    localparam int CTX_SEG_END = 2;
    localparam int CTX_IMG_END = 3;

    typedef enum logic [1:0] {
        BEAT_DATA    = 2'd0,
        BEAT_SEG_END = 2'd1,
        BEAT_IMG_END = 2'd2
    } beat_kind_e;

    // Builds the context word for a beat from its kind and the header flags.
    function automatic logic [CTX_W-1:0] make_ctx(beat_kind_e kind, logic hv, logic hb);
        logic [CTX_W-1:0] c;
        c              = '0;
        c[CTX_HDR_OK]  = hv;
        c[CTX_BANK]    = hb;
        c[CTX_SEG_END] = (kind != BEAT_DATA);
        c[CTX_IMG_END] = (kind == BEAT_IMG_END);
        return c;
    endfunction

endpackage

// File: rtl/jpeg_unstuff_classify.sv
// Combinational byte classifier.
// Given whether an escape byte is pending and the current byte, decides
// whether a beat is produced, of which kind and with which data, and whether
// an escape stays pending afterwards. Assumes it is evaluated only for
// accepted bytes; the caller gates the results with the accept condition.
module jpeg_unstuff_classify
    import jpeg_unstuff_pkg::*;
#(
    parameter int            W         = 8,
    parameter logic [W-1:0]  ESC       = 8'hFF,
    parameter logic [W-1:0]  STUFF     = 8'h00,
    parameter logic [W-1:0]  IMG_END   = 8'hD9,
    parameter logic [W-1:0]  RST_FIRST = 8'hD0,
    parameter int            RST_NUM   = 8
) (
    input  logic             pending,
    input  logic [W-1:0]     byte_in,
    output logic             next_pending,
    output logic             emit,
    output beat_kind_e       kind,
    output logic [W-1:0]     data_out
);

    logic [RST_NUM-1:0] rst_hit;
    logic               is_restart;

    // One equality comparator per restart code.
    for (genvar g = 0; g < RST_NUM; g++) begin : g_rst_cmp
        localparam logic [W-1:0] CODE = RST_FIRST + W'(g);
        assign rst_hit[g] = (byte_in == CODE);
    end
    assign is_restart = |rst_hit;

    // Decide the fate of the current byte from the escape state.
    always_comb begin
        next_pending = 1'b0;
        emit         = 1'b0;
        kind         = BEAT_DATA;
        data_out     = byte_in;
        if (!pending) begin
            if (byte_in == ESC) begin
                next_pending = 1'b1;
            end else begin
                emit = 1'b1;
            end
        end else begin
            if (byte_in == STUFF) begin
                emit     = 1'b1;
                data_out = ESC;
            end else if (byte_in == ESC) begin
                next_pending = 1'b1;
            end else if (byte_in == IMG_END) begin
                emit     = 1'b1;
                kind     = BEAT_IMG_END;
                data_out = '0;
            end else if (is_restart) begin
                emit     = 1'b1;
                kind     = BEAT_SEG_END;
                data_out = '0;
            end
        end
    end

endmodule

// File: rtl/jpeg_unstuff_escape_track.sv
// Holds the "escape byte seen" flag between accepted bytes.
// Assumes advance is high only in cycles where a byte is consumed.
module jpeg_unstuff_escape_track (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic next_pending,
    output logic pending
);

    // Update the escape flag on each consumed byte; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (advance) begin
            pending <= next_pending;
        end
    end

endmodule

// File: rtl/jpeg_unstuff_out_stage.sv
// Output register stage: holds one beat (data + context) and the
// end-of-image pulse. Advances only when downstream is ready; assumes the
// caller raises load only in cycles where out_ready is high.
module jpeg_unstuff_out_stage
    import jpeg_unstuff_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_ready,
    input  logic              load,
    input  beat_kind_e        load_kind,
    input  logic [W-1:0]      load_data,
    input  logic              hdr_valid,
    input  logic              hdr_bank,
    output logic              out_valid,
    output logic [W-1:0]      out_data,
    output logic [CTX_W-1:0]  out_ctx,
    output logic              img_end
);

    // Register a new beat when downstream moves; hold everything otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ctx   <= '0;
        end else if (out_ready) begin
            out_valid <= load;
            if (load) begin
                out_data <= load_data;
                out_ctx  <= make_ctx(load_kind, hdr_valid, hdr_bank);
            end
        end
    end

    // Pulse the end-of-image flag for the single cycle after it is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_end <= 1'b0;
        end else begin
            img_end <= out_ready && load && (load_kind == BEAT_IMG_END);
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctx))); // R8
    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !load) |=> !out_valid); // R9
    AST_IMG_END_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        img_end |-> (out_valid && out_ctx[CTX_IMG_END] && out_ctx[CTX_SEG_END])); // R6
    AST_IMG_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        img_end |=> !img_end); // R6

endmodule

// File: rtl/jpeg_scan_unstuffer.sv
// Top of the scan byte unstuffer. Consumes one byte per cycle whenever
// downstream is ready, classifies it against the pending escape state and
// registers the resulting beat with its context. Assumes the input buffer
// presents a byte with in_valid and keeps it until in_ready is seen.
module jpeg_scan_unstuffer
    import jpeg_unstuff_pkg::*;
#(
    parameter int           W         = BYTE_W,
    parameter logic [W-1:0] ESC       = 8'hFF,
    parameter logic [W-1:0] STUFF     = 8'h00,
    parameter logic [W-1:0] IMG_END   = 8'hD9,
    parameter logic [W-1:0] RST_FIRST = 8'hD0,
    parameter int           RST_NUM   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    output logic             in_ready,
    input  logic             hdr_valid,
    input  logic             hdr_bank,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    output logic [CTX_W-1:0] out_ctx,
    input  logic             out_ready,
    output logic             img_end
);

    logic         accept;
    logic         pending;
    logic         next_pending;
    logic         emit;
    beat_kind_e   kind;
    logic [W-1:0] cls_data;
    logic         load;

    // Input is taken only when the output stage may move.
    assign in_ready = out_ready;
    assign accept   = in_valid && out_ready;
    assign load     = accept && emit;

    jpeg_unstuff_classify #(
        .W(W), .ESC(ESC), .STUFF(STUFF), .IMG_END(IMG_END),
        .RST_FIRST(RST_FIRST), .RST_NUM(RST_NUM)
    ) u_classify (
        .pending      (pending),
        .byte_in      (in_data),
        .next_pending (next_pending),
        .emit         (emit),
        .kind         (kind),
        .data_out     (cls_data)
    );

    jpeg_unstuff_escape_track u_escape (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance      (accept),
        .next_pending (next_pending),
        .pending      (pending)
    );

    jpeg_unstuff_out_stage #(.W(W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_ready  (out_ready),
        .load       (load),
        .load_kind  (kind),
        .load_data  (cls_data),
        .hdr_valid  (hdr_valid),
        .hdr_bank   (hdr_bank),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ctx    (out_ctx),
        .img_end    (img_end)
    );

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pending && in_data != ESC) |=> (out_valid && out_data == $past(in_data))); // R1
    AST_STUFF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pending && in_data == STUFF) |=> (out_valid && out_data == ESC && out_ctx[3:2] == 2'b00)); // R2
    AST_ESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_data == ESC) |=> !out_valid); // R3
    AST_FILL_KEEPS_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_data == ESC) |=> pending); // R4
    AST_HDR_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_ctx[1:0] == {$past(hdr_bank), $past(hdr_valid)})); // R7
    AST_IMG_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pending && in_data == IMG_END) |=> img_end); // R6

endmodule

// File: tb/jpeg_scan_unstuffer_test.sv
`timescale 1ns/1ps
module jpeg_scan_unstuffer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       hdr_valid = 1'b0;
    logic       hdr_bank = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic [3:0] out_ctx;
    logic       out_ready = 1'b0;
    logic       img_end;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic       m_pend = 1'b0;
    logic       e_valid = 1'b0;
    logic [7:0] e_data = 8'h00;
    logic [3:0] e_ctx = 4'h0;
    logic       e_eoi = 1'b0;
    string      e_tag = "R10";
    logic       post_reset = 1'b0;

    always #5 clk = ~clk;

    jpeg_scan_unstuffer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .hdr_valid(hdr_valid), .hdr_bank(hdr_bank),
        .out_valid(out_valid), .out_data(out_data), .out_ctx(out_ctx),
        .out_ready(out_ready), .img_end(img_end)
    );

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare outputs against the model (at falling edge).
    task automatic compare();
        check(e_tag, "out_valid", {7'd0, out_valid}, {7'd0, e_valid});
        check("R8", "in_ready", {7'd0, in_ready}, {7'd0, out_ready});
        check((e_eoi || e_tag == "R6") ? "R6" : e_tag, "img_end", {7'd0, img_end}, {7'd0, e_eoi});
        if (e_valid || e_tag == "R10") begin
            check(e_tag, "out_data", out_data, e_data);
            check(e_tag, "out_ctx[3:2]", {6'd0, out_ctx[3:2]}, {6'd0, e_ctx[3:2]});
            check(e_tag == "R10" ? "R10" : "R7", "out_ctx[1:0]", {6'd0, out_ctx[1:0]}, {6'd0, e_ctx[1:0]});
        end
    endtask

    // One cycle: compare, drive new inputs, advance the model, move to next falling edge.
    task automatic step(logic rs, logic v, logic [7:0] b, logic rdy);
        logic hv, hb;
        compare();
        hv = 1'($urandom_range(0, 1));
        hb = 1'($urandom_range(0, 1));
        rst_n = rs; in_valid = v; in_data = b; out_ready = rdy;
        hdr_valid = hv; hdr_bank = hb;
        if (!rs) begin
            m_pend = 1'b0; e_valid = 1'b0; e_data = 8'h00; e_ctx = 4'h0; e_eoi = 1'b0;
            e_tag = "R10"; post_reset = 1'b1;
        end else if (!rdy) begin
            e_eoi = 1'b0;
            e_tag = e_valid ? "R8" : "R9";
        end else begin
            e_eoi = 1'b0; e_valid = 1'b0; e_tag = "R9";
            if (v) begin
                if (!m_pend) begin
                    if (b == 8'hFF) begin m_pend = 1'b1; e_tag = "R3"; end
                    else begin
                        e_valid = 1'b1; e_data = b; e_ctx = {2'b00, hb, hv};
                        e_tag = post_reset ? "R10" : "R1";
                    end
                end else if (b == 8'h00) begin
                    m_pend = 1'b0; e_valid = 1'b1; e_data = 8'hFF; e_ctx = {2'b00, hb, hv}; e_tag = "R2";
                end else if (b == 8'hFF) begin
                    e_tag = "R4";
                end else if (b == 8'hD9) begin
                    m_pend = 1'b0; e_valid = 1'b1; e_data = 8'h00; e_ctx = {2'b11, hb, hv};
                    e_eoi = 1'b1; e_tag = "R6";
                end else if (b >= 8'hD0 && b <= 8'hD7) begin
                    m_pend = 1'b0; e_valid = 1'b1; e_data = 8'h00; e_ctx = {2'b01, hb, hv}; e_tag = "R5";
                end else begin
                    m_pend = 1'b0; e_tag = "R3";
                end
                post_reset = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    // Offer one byte until it is taken; stall with probability given by pct.
    task automatic push(logic [7:0] b, int stall_pct);
        logic rdy;
        do begin
            rdy = ($urandom_range(0, 99) >= stall_pct);
            step(1'b1, 1'b1, b, rdy);
        end while (!rdy);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b1);
    endtask

    function automatic logic [7:0] rand_byte();
        int r;
        r = $urandom_range(0, 99);
        if (r < 25) return 8'hFF;
        if (r < 40) return 8'h00;
        if (r < 50) return 8'hD0 + 8'($urandom_range(0, 7));
        if (r < 55) return 8'hD9;
        return 8'($urandom_range(0, 255));
    endfunction

    initial begin
        #1ms;
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        // R10: reset state checked by compare at this edge.
        idle(2);
        // R1 plain bytes
        push(8'h41, 0); push(8'h00, 0); push(8'hC4, 0); idle(1);
        // R2 stuffed pair
        push(8'hFF, 0); push(8'h00, 0); idle(1);
        // R4 fill chain then stuff
        push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 0); push(8'h00, 0); idle(1);
        // R5 restart markers at both ends of the range
        push(8'hFF, 0); push(8'hD0, 0); push(8'hFF, 0); push(8'hD7, 0); idle(1);
        // R3 other markers dropped, and the code right past the restart range
        push(8'hFF, 0); push(8'hC4, 0); push(8'hFF, 0); push(8'hD8, 0); push(8'h12, 0); idle(1);
        // R6 end of image after fill
        push(8'hFF, 0); push(8'hFF, 0); push(8'hD9, 0); idle(2);
        // R8 stalls around a held beat
        push(8'h5A, 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'hFF, 1'b0);
        idle(1);
        // R10 reset clears a pending escape: the next 0x00 is plain data
        push(8'hFF, 0);
        step(1'b0, 1'b1, 8'h00, 1'b1);
        push(8'h00, 0); idle(1);
        // Random mix with stalls and gaps
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) < 2) step(1'b1, 1'b0, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
            else push(rand_byte(), 30);
        end
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule